// File: doc/BRIEF.md
# Interlocked Multiplexed Bus Slave Endpoint

This block is the slave side of a 16-bit multiplexed bus whose transfers are fully interlocked: each word is held until the receiver acknowledges it. It watches every address broadcast and acknowledges it whether or not the address is meant for it. It keeps the address word, and it decides from a base value and a mask whether later data words concern it. Once selected, it accepts write words from the master and passes them to local registers through a one-cycle write pulse. In read mode it takes over the ready strobe: it drives a word from the local read port onto the bus, raises the strobe after a setup delay, and releases the bus a fixed hold time after the master's acknowledge.

Every received word, address or write data, is checked for odd parity over the 16 data bits and one parity line. A bad word raises an error line one cycle before the acknowledge, so the master sees the error before the handshake completes. All bus inputs are taken to be already synchronised to `clk`. All strobes here are active high; inverting them for the wire is done outside the block.

Top module: `bus_slave_ep`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `bus_aack_o`, `bus_dack_o`, `bus_err_o`, `bus_rdy_o`, `bus_ad_oe`, `usr_wr_stb` and `usr_rd_take` are 0 and `usr_addr` is 0.
- R2: When `bus_rdy_in` is sampled high with `bus_addr_phase`=1 and parity is good, `bus_aack_o` goes high on the next cycle. This happens whether or not the address selects this slave. It stays high while `bus_rdy_in` stays high.
- R3: `bus_aack_o`, `bus_dack_o` and `bus_err_o` fall on the cycle after `bus_rdy_in` is sampled low.
- R4: An address word with good parity is copied to `usr_addr`, and it selects the slave iff `(addr & MASK) == (BASE & MASK)`. An address word with bad parity deselects the slave and leaves `usr_addr` unchanged.
- R5: In write mode (`bus_addr_phase`=0, `bus_rd_nwr`=0), a selected slave that samples `bus_rdy_in` high with good parity pulses `usr_wr_stb` for one cycle with the word on `usr_wr_data`, and raises `bus_dack_o`, both on the next cycle. An unselected slave raises neither.
- R6: A word is good when bits `bus_ad_in` and `bus_par_in` together hold an odd number of ones. On a bad received word, `bus_err_o` rises on the cycle after the strobe and the accept line rises one cycle later. A bad write word gives no `usr_wr_stb`.
- R7: A selected slave in read mode (`bus_rd_nwr`=1, `bus_addr_phase`=0, `bus_rdy_in` and `bus_dack_in` low) drives `bus_ad_oe`=1 on the next cycle, with `usr_rd_data` on `bus_ad_out` and a one-cycle `usr_rd_take`. `bus_rdy_o` rises SETUP_CYC cycles after `bus_ad_oe`.
- R8: `bus_rdy_o` falls on the cycle after `bus_dack_in` is sampled high. `bus_ad_oe` falls HOLD_CYC cycles after that. The next word starts only after `bus_dack_in` is seen low.
- R9: `bus_par_out` gives odd parity for the driven word.
- R10: An unselected slave never raises `bus_ad_oe`, `bus_rdy_o` or `usr_rd_take` in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad_in | input | 16 | Received address/data word |
| bus_par_in | input | 1 | Received parity bit |
| bus_addr_phase | input | 1 | 1 = address word, 0 = data word |
| bus_rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_rdy_in | input | 1 | Ready strobe from the talking master |
| bus_dack_in | input | 1 | Data acknowledge from the master in reads |
| bus_aack_o | output | 1 | Contribution to the shared address accept |
| bus_dack_o | output | 1 | Data acknowledge in writes |
| bus_err_o | output | 1 | Parity error report |
| bus_rdy_o | output | 1 | Ready strobe while talking |
| bus_ad_oe | output | 1 | Enable for the word driver |
| bus_ad_out | output | 16 | Word driven in reads |
| bus_par_out | output | 1 | Parity of the driven word |
| usr_addr | output | 16 | Last good address word |
| usr_wr_stb | output | 1 | One-cycle local write pulse |
| usr_wr_data | output | 16 | Local write data |
| usr_rd_data | input | 16 | Local read data |
| usr_rd_take | output | 1 | Read word consumed |

## Verification
Accepts, the write pulse and the start of a read are due one clock after the input is sampled, and a parity error moves the accept one clock later. The read strobe is due SETUP_CYC clocks after the driver enable, and the enable falls HOLD_CYC clocks after the strobe ends. The bench keeps an expected value for every output and updates it in the order these latencies give. It compares all outputs a short time after every rising edge, so each result is checked in exactly the cycle it is due, and also in every cycle before and after.

// File: rtl/slv_pkg.sv
// Shared types for the bus slave endpoint.
// Assumes: nothing beyond SystemVerilog enums.
package slv_pkg;
    typedef enum logic [1:0] {L_IDLE, L_ERR, L_ACK} lsn_state_t;
    typedef enum logic [2:0] {T_IDLE, T_SETUP, T_STRB, T_HOLD, T_WAIT} tlk_state_t;
    typedef enum logic {K_ADDR, K_WRITE} cyc_kind_t;
endpackage

// File: rtl/slv_parity.sv
// Odd-parity check for a received word and odd-parity generation for a
// word to be sent. Assumes: purely combinational, word width DW.
module slv_parity #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rx_word,
    input  logic          rx_par,
    input  logic [DW-1:0] tx_word,
    output logic          rx_ok,
    output logic          tx_par
);
    // Good word: odd number of ones over word and parity bit.
    always_comb rx_ok = ^{rx_word, rx_par};
    // Parity bit that makes the sent word odd.
    always_comb tx_par = ~(^tx_word);
endmodule

// File: rtl/slv_addr_dec.sv
// Holds the last good address word and the select flag derived from it.
// Assumes: load is a one-cycle request from the listener; a bad-parity
// address deselects and keeps the previous address.
module slv_addr_dec #(
    parameter int          DW   = 16,
    parameter logic [DW-1:0] BASE = 16'h1200,
    parameter logic [DW-1:0] MASK = 16'hFF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_ok,
    input  logic [DW-1:0] addr_in,
    output logic          sel,
    output logic [DW-1:0] addr_q
);
    logic hit;

    // Compare the incoming address with the base under the mask.
    always_comb hit = ((addr_in ^ BASE) & MASK) == '0;

    // Capture address and selection on each address word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= 1'b0;
            addr_q <= '0;
        end else if (load) begin
            if (load_ok) begin
                sel    <= hit;
                addr_q <= addr_in;
            end else begin
                sel    <= 1'b0;
            end
        end
    end

    AST_SEL_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> ((addr_q & MASK) == (BASE & MASK))); // R4
endmodule

// File: rtl/slv_listener.sv
// Listener side: acknowledges every address word and the write words of a
// selected slave, reports parity errors one cycle ahead of the accept.
// Assumes: the master holds its strobe until the accept is seen.
module slv_listener #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_in,
    input  logic          addr_phase,
    input  logic          rd_nwr,
    input  logic          sel,
    input  logic          par_ok,
    input  logic [DW-1:0] ad_in,
    output logic          addr_load,
    output logic          aack,
    output logic          dack,
    output logic          err,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);
    import slv_pkg::*;

    lsn_state_t st;
    cyc_kind_t  kind;
    logic       take_addr;
    logic       take_wr;

    // Decide which kind of word is being offered this cycle.
    always_comb begin
        take_addr = (st == L_IDLE) && strobe_in && addr_phase;
        take_wr   = (st == L_IDLE) && strobe_in && !addr_phase && !rd_nwr && sel;
        addr_load = take_addr;
    end

    // Handshake sequencing for address and write words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= L_IDLE;
            kind    <= K_ADDR;
            err     <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            case (st)
                L_IDLE: begin
                    if (take_addr || take_wr) begin
                        kind <= take_addr ? K_ADDR : K_WRITE;
                        if (par_ok) begin
                            st <= L_ACK;
                            if (take_wr) begin
                                wr_stb  <= 1'b1;
                                wr_data <= ad_in;
                            end
                        end else begin
                            st  <= L_ERR;
                            err <= 1'b1;
                        end
                    end
                end
                L_ERR: st <= L_ACK;
                L_ACK: begin
                    if (!strobe_in) begin
                        st  <= L_IDLE;
                        err <= 1'b0;
                    end
                end
                default: st <= L_IDLE;
            endcase
        end
    end

    // Accept outputs follow the handshake state and the word kind.
    always_comb begin
        aack = (st == L_ACK) && (kind == K_ADDR);
        dack = (st == L_ACK) && (kind == K_WRITE);
    end

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(aack) || $rose(dack)) |-> $past(strobe_in)); // R2
    AST_ERR_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !(aack || dack)); // R6
    AST_ACCEPT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((aack || dack) && !strobe_in) |=> !(aack || dack || err)); // R3
    AST_WSTB_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (dack && !err)); // R5
endmodule

// File: rtl/slv_talker.sv
// Talker side for reads: drives a local word, raises the ready strobe after
// SETUP_CYC cycles, drops it on the acknowledge and frees the bus HOLD_CYC
// cycles later. Assumes: SETUP_CYC and HOLD_CYC are at least 1.
module slv_talker #(
    parameter int DW        = 16,
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          addr_phase,
    input  logic          rd_nwr,
    input  logic          strobe_in,
    input  logic          dack_in,
    input  logic [DW-1:0] rd_data,
    input  logic          tx_par,
    output logic          strobe_o,
    output logic          oe,
    output logic [DW-1:0] ad_out,
    output logic          par_out,
    output logic          rd_take
);
    import slv_pkg::*;

    localparam int MAXC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

    tlk_state_t    st;
    logic [CW-1:0] cnt;
    logic          start;

    // A new word may start only on a quiet bus in selected read mode.
    always_comb start = (st == T_IDLE) && sel && !addr_phase && rd_nwr
                        && !strobe_in && !dack_in;

    // Read word sequencing: setup, strobe, hold, wait for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= T_IDLE;
            cnt     <= '0;
            oe      <= 1'b0;
            ad_out  <= '0;
            par_out <= 1'b0;
            rd_take <= 1'b0;
        end else begin
            rd_take <= 1'b0;
            case (st)
                T_IDLE: begin
                    if (start) begin
                        ad_out  <= rd_data;
                        par_out <= tx_par;
                        oe      <= 1'b1;
                        rd_take <= 1'b1;
                        cnt     <= '0;
                        st      <= T_SETUP;
                    end
                end
                T_SETUP: begin
                    if (cnt == SETUP_LAST) st <= T_STRB;
                    else cnt <= cnt + 1'b1;
                end
                T_STRB: begin
                    if (dack_in) begin
                        cnt <= '0;
                        st  <= T_HOLD;
                    end
                end
                T_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        oe <= 1'b0;
                        st <= T_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                T_WAIT: if (!dack_in) st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end

    // The ready strobe is the strobe state itself.
    always_comb strobe_o = (st == T_STRB);

    AST_OE_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> oe); // R7
    AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && dack_in) |=> !strobe_o); // R8
    AST_TAKE_STARTS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> (oe && !strobe_o && $past(sel))); // R7
    AST_PAR_OUT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (^{ad_out, par_out})); // R9
endmodule

// File: rtl/bus_slave_ep.sv
// Top of the slave endpoint: joins parity logic, address decoder, listener
// and talker. Assumes: all bus inputs synchronous to clk, active-high
// strobes, and no read and write activity at the same time.
module bus_slave_ep #(
    parameter int            DW        = 16,
    parameter logic [DW-1:0] BASE      = 16'h1200,
    parameter logic [DW-1:0] MASK      = 16'hFF00,
    parameter int            SETUP_CYC = 3,
    parameter int            HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_ad_in,
    input  logic          bus_par_in,
    input  logic          bus_addr_phase,
    input  logic          bus_rd_nwr,
    input  logic          bus_rdy_in,
    input  logic          bus_dack_in,
    output logic          bus_aack_o,
    output logic          bus_dack_o,
    output logic          bus_err_o,
    output logic          bus_rdy_o,
    output logic          bus_ad_oe,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_par_out,
    output logic [DW-1:0] usr_addr,
    output logic          usr_wr_stb,
    output logic [DW-1:0] usr_wr_data,
    input  logic [DW-1:0] usr_rd_data,
    output logic          usr_rd_take
);
    logic par_ok;
    logic tx_par;
    logic sel;
    logic addr_load;

    slv_parity #(.DW(DW)) u_par (
        .rx_word (bus_ad_in),
        .rx_par  (bus_par_in),
        .tx_word (usr_rd_data),
        .rx_ok   (par_ok),
        .tx_par  (tx_par)
    );

    slv_addr_dec #(.DW(DW), .BASE(BASE), .MASK(MASK)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_ok (par_ok),
        .addr_in (bus_ad_in),
        .sel     (sel),
        .addr_q  (usr_addr)
    );

    slv_listener #(.DW(DW)) u_lsn (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (bus_rdy_in),
        .addr_phase (bus_addr_phase),
        .rd_nwr     (bus_rd_nwr),
        .sel        (sel),
        .par_ok     (par_ok),
        .ad_in      (bus_ad_in),
        .addr_load  (addr_load),
        .aack       (bus_aack_o),
        .dack       (bus_dack_o),
        .err        (bus_err_o),
        .wr_stb     (usr_wr_stb),
        .wr_data    (usr_wr_data)
    );

    slv_talker #(.DW(DW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_tlk (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .addr_phase (bus_addr_phase),
        .rd_nwr     (bus_rd_nwr),
        .strobe_in  (bus_rdy_in),
        .dack_in    (bus_dack_in),
        .rd_data    (usr_rd_data),
        .tx_par     (tx_par),
        .strobe_o   (bus_rdy_o),
        .oe         (bus_ad_oe),
        .ad_out     (bus_ad_out),
        .par_out    (bus_par_out),
        .rd_take    (usr_rd_take)
    );

    AST_DACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dack_o) |-> $past(sel)); // R5
    AST_NO_DRIVE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ad_oe && bus_dack_o)); // R10
    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ad_oe) |-> $past(sel)); // R10
endmodule

// File: tb/bus_slave_ep_tb.sv
module bus_slave_ep_tb_top;
    localparam logic [15:0] BASE  = 16'h1200;
    localparam logic [15:0] MASK  = 16'hFF00;
    localparam int          SETUP = 3;
    localparam int          HOLD  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] ad_in = '0;
    logic par_in = 1'b0, addr_ph = 1'b0, rnw = 1'b0, rdy_in = 1'b0, dack_in = 1'b0;
    logic aack, dack, err, rdy_o, oe, par_out, wr_stb, rd_take;
    logic [15:0] ad_out, uaddr, wr_data;
    logic [15:0] rd_data = '0;

    always #10 clk = ~clk;

    bus_slave_ep #(.DW(16), .BASE(BASE), .MASK(MASK), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_ad_in(ad_in), .bus_par_in(par_in),
        .bus_addr_phase(addr_ph), .bus_rd_nwr(rnw), .bus_rdy_in(rdy_in),
        .bus_dack_in(dack_in), .bus_aack_o(aack), .bus_dack_o(dack),
        .bus_err_o(err), .bus_rdy_o(rdy_o), .bus_ad_oe(oe), .bus_ad_out(ad_out),
        .bus_par_out(par_out), .usr_addr(uaddr), .usr_wr_stb(wr_stb),
        .usr_wr_data(wr_data), .usr_rd_data(rd_data), .usr_rd_take(rd_take)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string req = "R1";
    // expected outputs after the coming edge
    logic e_aack, e_dack, e_err, e_rdy, e_oe, e_wstb, e_take;
    logic [15:0] e_wdata, e_adout, m_addr;
    bit m_sel;

    function automatic logic good_par(input logic [15:0] w);
        return ($countones(w) % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic clr_exp();
        e_aack = 0; e_dack = 0; e_err = 0; e_rdy = 0; e_oe = 0; e_wstb = 0; e_take = 0;
    endtask

    task automatic cmp(input string nm, input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, nm, act, exp, cyc);
        end
    endtask

    // Advance one clock and compare every output.
    task automatic tick();
        @(posedge clk);
        #2;
        n_chk++;
        cmp("aack", 16'(aack), 16'(e_aack));
        cmp("dack", 16'(dack), 16'(e_dack));
        cmp("err", 16'(err), 16'(e_err));
        cmp("rdy_o", 16'(rdy_o), 16'(e_rdy));
        cmp("oe", 16'(oe), 16'(e_oe));
        cmp("wr_stb", 16'(wr_stb), 16'(e_wstb));
        cmp("rd_take", 16'(rd_take), 16'(e_take));
        cmp("usr_addr", uaddr, m_addr);
        if (e_wstb) cmp("wr_data", wr_data, e_wdata);
        if (e_oe) begin
            cmp("ad_out", ad_out, e_adout);
            cmp("par_out", 16'(par_out), 16'(good_par(e_adout)));
        end
    endtask

    // Address word; R2 accept from every slave, R4 selection, R6 error.
    task automatic addr_cycle(input logic [15:0] a, input bit bad);
        req = bad ? "R6" : "R2";
        ad_in = a; par_in = good_par(a) ^ bad; addr_ph = 1; rnw = 0; rdy_in = 1;
        clr_exp();
        if (bad) begin
            e_err = 1; tick();
            e_aack = 1; tick();
            m_sel = 0;
        end else begin
            m_addr = a;
            m_sel = ((a & MASK) == (BASE & MASK));
            e_aack = 1; tick();
        end
        tick();
        req = "R3";
        rdy_in = 0; clr_exp(); tick();
    endtask

    // Write word; R5 for selected/unselected, R6 on bad parity.
    task automatic write_cycle(input logic [15:0] d, input bit bad);
        req = bad ? "R6" : "R5";
        ad_in = d; par_in = good_par(d) ^ bad; addr_ph = 0; rnw = 0; rdy_in = 1;
        clr_exp();
        if (!m_sel) begin
            tick(); tick();
        end else if (bad) begin
            e_err = 1; tick();
            e_dack = 1; tick();
        end else begin
            e_wstb = 1; e_wdata = d; e_dack = 1; tick();
            e_wstb = 0; tick();
        end
        req = "R3";
        rdy_in = 0; clr_exp(); tick();
    endtask

    // One read word with dly strobe cycles before the acknowledge (R7, R8, R9).
    task automatic read_word(input logic [15:0] d, input int dly, input bit last);
        req = "R7";
        addr_ph = 0; rnw = 1; rdy_in = 0; rd_data = d;
        clr_exp();
        e_oe = 1; e_take = 1; e_adout = d; tick();
        e_take = 0;
        for (int i = 1; i < SETUP; i++) tick();
        e_rdy = 1; tick();
        for (int i = 0; i < dly; i++) tick();
        req = "R8";
        dack_in = 1; e_rdy = 0; tick();
        for (int i = 1; i < HOLD; i++) tick();
        e_oe = 0; tick();
        tick();
        dack_in = 0;
        if (last) rnw = 0;
        tick();
    endtask

    initial begin
        m_addr = '0; m_sel = 0; e_wdata = '0; e_adout = '0;
        clr_exp();
        req = "R1";
        tick(); tick();
        rst_n = 1;
        tick();

        addr_cycle(16'h1234, 0);              // R4 selects
        write_cycle(16'hA5A5, 0);             // R5 selected write
        write_cycle(16'h0F0E, 1);             // R6 bad write parity
        read_word(16'hBEEF, 0, 0);            // R7 first read word
        read_word(16'h1357, 2, 1);            // R8 next word after release, R9 parity

        addr_cycle(16'h3400, 0);              // R2 unselected still accepts, R4
        write_cycle(16'h7777, 0);             // R5 unselected: no strobe
        req = "R10";
        addr_ph = 0; rnw = 1; rd_data = 16'h4242; clr_exp();
        for (int i = 0; i < 6; i++) tick();   // R10 no drive when unselected
        rnw = 0; tick();

        addr_cycle(16'h12C0, 0);              // R4 selects again
        addr_cycle(16'h12FF, 1);              // R4 bad address deselects, usr_addr kept
        write_cycle(16'h5555, 0);             // R4 ignored after deselect
        addr_cycle(16'h12C0, 0);
        write_cycle(16'h0001, 0);             // R5 single-bit word
        read_word(16'h0000, 1, 1);            // R9 all-zero word gets parity 1

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule